// File: doc/BRIEF.md
# Microcontroller GPIO Port Controller

This block is the register side of a small 8-bit microcontroller's general-purpose I/O. It serves seven 8-bit ports (port 0 to port 6). Each port has an output latch, a direction register and a read path. The block drives per-pin output value, output enable and pull-up enable signals toward the pads, and it takes the live pin levels back. The pad circuitry and any LCD segment driver sit outside. From the segment side the block only receives a per-pin "assigned to segment" flag, which cancels the grouped pull-ups on ports 0 to 2.

The CPU reaches the block over a plain register bus with an address, write data, a write strobe and combinational read data. Pull-ups are not enabled per pin. They are enabled per group, from two registers, and a pull-up is only applied to a pin that is an input. Port 3 has one more gate. Its pins drive only after a port-wide enable bit is set. Until then, which includes the whole time after reset, all eight of its pins are held pulled up.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every direction register, output latch, the port-3 gate bit and both pull-up registers are 0. All pin_oe bits and all pin_out bits are 0, and pin_pu is 1 only on the eight port-3 pins (pin_pu bits 31:24).
- R2: Pin b of port n maps to bit n*8+b of every pin bus. A direction bit of 1 sets pin_oe for that pin (port 3 is further gated, see R6). pin_out always carries the output latch. A direction register at 0x08+n reads back what is stored.
- R3: A read of the data address 0x00+n returns, bit by bit, the latch value for output pins and pin_in for input pins.
- R4: A write to a data address always updates the latch, so pin_out follows it. A pin whose direction is input keeps pin_oe at 0 after such a write.
- R5: Ports 0 and 1 store only bit 0 of their direction register. That bit sets the direction of all eight pins, and reads of 0x08 and 0x09 return bits 7:1 as 0.
- R6: Bit 0 of the register at 0x07 is the port-3 gate, and only bit 0 is stored. While it is 0, no port-3 pin has pin_oe set and all eight port-3 pins have pin_pu set. While it is 1, port-3 pin_oe follows direction and port-3 pin_pu is 0.
- R7: Pull-up register A at 0x16 enables groups, one bit each, with 1 meaning pull-up. The groups are b0 port 0 pins 0-1, b1 port 0 pins 2-3, b2 port 0 pins 4-7, b3 port 1 pins 0-3, b4 port 1 pins 4-5, b5 port 1 pins 6-7, b6 port 2 pins 0-3 and b7 port 2 pins 4-7.
- R8: Pull-up register B at 0x17 enables groups with b0 port 4 pins 1-3, b1 port 4 pins 4-7, b2 port 5 pins 0-3, b3 port 5 pins 4-7, b4 port 6 pins 0-3 and b5 port 6 pins 4-7. Bits 7:6 are not stored and read 0. Port-4 pin 0 is never pulled up.
- R9: A pin whose direction is output never has pin_pu set, whatever its group bit.
- R10: seg_assign bit k (pin k of ports 0-2, same bit numbering as R2) cancels the register-A pull-up of that pin. It has no effect on register-B pull-ups.
- R11: A write takes effect on the rising clock edge at which bus_we is high, not before. Addresses 0x0F-0x15 and 0x18-0x1F read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 56 | Live pin levels, bit n*8+b |
| seg_assign | input | 24 | Pin assigned to segment output, ports 0-2 |
| pin_out | output | 56 | Output latch value per pin |
| pin_oe | output | 56 | Output drive enable per pin |
| pin_pu | output | 56 | Pull-up enable per pin |

## Verification
The assertions check several properties on every cycle. No pin is ever both driven and pulled up. Port 0, port 1 and port 3 switch their enables as whole ports. The read path of port 0 follows direction bit by bit. Unmapped addresses and the unused bits of register B read 0, and a data write lands on the following cycle. Only the bench's scenarios show the group-to-pin mapping of each pull-up bit, the reset image, and the segment override acting on register A but not on register B. They also show that a pin holds its enable for the full cycle in which a write is pending, and the read-back mix of latch and pin values after sequences of direction changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W     = 8;
    localparam int NUM_PORTS  = 7;
    localparam int ADDR_W     = 5;
    localparam int SEG_PORTS  = 3;
    localparam int PUA_BITS   = 8;
    localparam int PUB_USED   = 6;
    localparam int PU_BITS    = PUA_BITS + PUB_USED;
    localparam int GATED_PORT = 3;
    localparam int PIN_CNT    = NUM_PORTS * PORT_W;
    localparam int SEG_CNT    = SEG_PORTS * PORT_W;

    localparam logic [ADDR_W-1:0] A_DATA_BASE = 5'h00;
    localparam logic [ADDR_W-1:0] A_GATE      = 5'h07;
    localparam logic [ADDR_W-1:0] A_DIR_BASE  = 5'h08;
    localparam logic [ADDR_W-1:0] A_PULL_A    = 5'h16;
    localparam logic [ADDR_W-1:0] A_PULL_B    = 5'h17;

    typedef logic [PORT_W-1:0] byte_t;

    typedef struct packed {
        byte_t [NUM_PORTS-1:0] latch;
        byte_t [NUM_PORTS-1:0] dir;
        logic                  gate_en;
        logic [PU_BITS-1:0]    pull;   // {B[5:0], A[7:0]}
    } gpio_state_t;

    // Ports whose direction is a single bit for the whole port.
    function automatic bit single_dir(input int port);
        return (port == 0) || (port == 1);
    endfunction

    function automatic byte_t dir_store_mask(input int port);
        return single_dir(port) ? byte_t'(8'h01) : byte_t'(8'hFF);
    endfunction

    // Index into the pull vector for a pin, or -1 when the pin has no group.
    function automatic int pull_index(input int port, input int pin);
        case (port)
            0: return (pin < 2) ? 0 : (pin < 4) ? 1 : 2;
            1: return (pin < 4) ? 3 : (pin < 6) ? 4 : 5;
            2: return (pin < 4) ? 6 : 7;
            4: return (pin == 0) ? -1 : (pin < 4) ? 8 : 9;
            5: return (pin < 4) ? 10 : 11;
            6: return (pin < 4) ? 12 : 13;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output gpio_state_t       st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (we) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr == A_DATA_BASE + ADDR_W'(p))
                    st.latch[p] <= wdata;
                if (addr == A_DIR_BASE + ADDR_W'(p))
                    st.dir[p] <= wdata & dir_store_mask(p);
            end
            if (addr == A_GATE)
                st.gate_en <= wdata[0];
            if (addr == A_PULL_A)
                st.pull[PUA_BITS-1:0] <= wdata;
            if (addr == A_PULL_B)
                st.pull[PU_BITS-1:PUA_BITS] <= wdata[PUB_USED-1:0];
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  byte_t              latch,
    input  byte_t              dir,
    input  logic               gate_en,
    input  logic [PU_BITS-1:0] pull,
    input  byte_t              seg,
    output byte_t              eff_dir,
    output byte_t              out,
    output byte_t              oe,
    output byte_t              pu
);

    localparam bit IS_SINGLE = single_dir(PORT_IDX);
    localparam bit IS_GATED  = (PORT_IDX == GATED_PORT);

    assign eff_dir = IS_SINGLE ? {PORT_W{dir[0]}} : dir;
    assign out     = latch;

    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
        localparam int PI = pull_index(PORT_IDX, b);
        if (IS_GATED) begin : g_gated
            assign oe[b] = eff_dir[b] & gate_en;
            assign pu[b] = ~gate_en;
        end else begin : g_plain
            logic grp;
            if (PI < 0) begin : g_nogrp
                assign grp = 1'b0;
            end else if (PI < PUA_BITS) begin : g_grpa
                assign grp = pull[PI] & ~seg[b];
            end else begin : g_grpb
                assign grp = pull[PI];
            end
            assign oe[b] = eff_dir[b];
            assign pu[b] = grp & ~eff_dir[b];
        end
    end

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  gpio_state_t           st,
    input  byte_t [NUM_PORTS-1:0] pins,
    input  byte_t [NUM_PORTS-1:0] eff_dir,
    output byte_t                 rdata
);

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == A_DATA_BASE + ADDR_W'(p))
                rdata = (st.latch[p] & eff_dir[p]) | (pins[p] & ~eff_dir[p]);
            if (addr == A_DIR_BASE + ADDR_W'(p))
                rdata = st.dir[p];
        end
        if (addr == A_GATE)
            rdata = {{(PORT_W-1){1'b0}}, st.gate_en};
        if (addr == A_PULL_A)
            rdata = st.pull[PUA_BITS-1:0];
        if (addr == A_PULL_B)
            rdata = {{(PORT_W-PUB_USED){1'b0}}, st.pull[PU_BITS-1:PUA_BITS]};
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [PORT_W-1:0]  bus_wdata,
    input  logic               bus_we,
    output logic [PORT_W-1:0]  bus_rdata,
    input  logic [PIN_CNT-1:0] pin_in,
    input  logic [SEG_CNT-1:0] seg_assign,
    output logic [PIN_CNT-1:0] pin_out,
    output logic [PIN_CNT-1:0] pin_oe,
    output logic [PIN_CNT-1:0] pin_pu
);

    gpio_state_t           st;
    byte_t [NUM_PORTS-1:0] eff_dir;
    byte_t [NUM_PORTS-1:0] pins;

    gpio_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .st    (st)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        byte_t seg_p;
        if (p < SEG_PORTS) begin : g_seg
            assign seg_p = seg_assign[p*PORT_W +: PORT_W];
        end else begin : g_noseg
            assign seg_p = '0;
        end
        assign pins[p] = pin_in[p*PORT_W +: PORT_W];

        gpio_pin_ctrl #(.PORT_IDX(p)) u_pins (
            .latch   (st.latch[p]),
            .dir     (st.dir[p]),
            .gate_en (st.gate_en),
            .pull    (st.pull),
            .seg     (seg_p),
            .eff_dir (eff_dir[p]),
            .out     (pin_out[p*PORT_W +: PORT_W]),
            .oe      (pin_oe[p*PORT_W +: PORT_W]),
            .pu      (pin_pu[p*PORT_W +: PORT_W])
        );
    end

    gpio_read_mux u_rd (
        .addr    (bus_addr),
        .st      (st),
        .pins    (pins),
        .eff_dir (eff_dir),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [PORT_W-1:0]  bus_wdata,
    input logic               bus_we,
    input logic [PORT_W-1:0]  bus_rdata,
    input logic [PIN_CNT-1:0] pin_in,
    input logic [SEG_CNT-1:0] seg_assign,
    input logic [PIN_CNT-1:0] pin_out,
    input logic [PIN_CNT-1:0] pin_oe,
    input logic [PIN_CNT-1:0] pin_pu
);

    logic unmapped;
    assign unmapped = (bus_addr >= 5'h0F && bus_addr <= 5'h15) || (bus_addr >= 5'h18);

    assert_no_drive_and_pull_R9: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_pu) == '0);

    assert_p0_whole_port_R5: assert property (@(posedge clk) disable iff (rst)
        pin_oe[7:0] == 8'h00 || pin_oe[7:0] == 8'hFF);

    assert_p1_whole_port_R5: assert property (@(posedge clk) disable iff (rst)
        pin_oe[15:8] == 8'h00 || pin_oe[15:8] == 8'hFF);

    assert_p3_pull_all_or_none_R6: assert property (@(posedge clk) disable iff (rst)
        pin_pu[31:24] == 8'h00 || pin_pu[31:24] == 8'hFF);

    assert_p3_drive_needs_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[31:24] != 8'h00) |-> (pin_pu[31:24] == 8'h00));

    assert_pullb_top_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h17) |-> (bus_rdata[7:6] == 2'b00));

    assert_p4_pin0_no_pull_R8: assert property (@(posedge clk) disable iff (rst)
        pin_pu[32] == 1'b0);

    assert_read_output_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h00 && pin_oe[0]) |-> (bus_rdata[0] == pin_out[0]));

    assert_read_input_pin_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 5'h00 && !pin_oe[0]) |-> (bus_rdata[0] == pin_in[0]));

    assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == 8'h00));

    assert_write_next_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == 5'h02) |=> (pin_out[23:16] == $past(bus_wdata)));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk chk_i (.*);

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [55:0] pin_in = 56'h7E_81_F0_0F_96_5A_3C;
    logic [23:0] seg_assign = '0;
    logic [55:0] pin_out, pin_oe, pin_pu;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [55:0] P3PU = 56'h00_00_00_FF_00_00_00;

    always #2 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .seg_assign(seg_assign), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    typedef struct packed {
        logic [4:0] wa;
        logic [7:0] wd;
        logic [4:0] ra;
        logic [7:0] ex;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{5'h02, 8'hAA, 5'h02, 8'h96, 4'd4},   // R4 input pin reads pin level
        '{5'h0A, 8'hF0, 5'h02, 8'hA6, 4'd3},   // R3 mixed latch/pin
        '{5'h08, 8'hFE, 5'h08, 8'h00, 4'd5},   // R5 only bit 0 stored
        '{5'h00, 8'h55, 5'h00, 8'h3C, 4'd5},   // R5 port 0 input
        '{5'h08, 8'h01, 5'h00, 8'h55, 4'd5},   // R5 bit 0 turns whole port out
        '{5'h17, 8'hFF, 5'h17, 8'h3F, 4'd8},   // R8 top bits zero
        '{5'h16, 8'h81, 5'h16, 8'h81, 4'd7},   // R7 readback
        '{5'h07, 8'hFF, 5'h07, 8'h01, 4'd6},   // R6 only bit 0 stored
        '{5'h10, 8'hFF, 5'h10, 8'h00, 4'd11},  // R11 unmapped
        '{5'h09, 8'h03, 5'h09, 8'h01, 4'd5},   // R5 port 1 dir
        '{5'h06, 8'h12, 5'h06, 8'h7E, 4'd4},   // R4 write to input port
        '{5'h0E, 8'hFF, 5'h0E, 8'hFF, 4'd2},   // R2 dir readback
        '{5'h1F, 8'h00, 5'h06, 8'h12, 4'd3}    // R3 output reads latch
    };

    task automatic chk(input logic [55:0] act, input logic [55:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [55:0] grp(input int k);
        case (k)
            0:  return 56'h03;
            1:  return 56'h0C;
            2:  return 56'hF0;
            3:  return 56'h0F << 8;
            4:  return 56'h30 << 8;
            5:  return 56'hC0 << 8;
            6:  return 56'h0F << 16;
            7:  return 56'hF0 << 16;
            8:  return 56'h0E << 32;
            9:  return 56'hF0 << 32;
            10: return 56'h0F << 40;
            11: return 56'hF0 << 40;
            12: return 56'h0F << 48;
            13: return 56'hF0 << 48;
            default: return '0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [55:0] s_out, s_oe, s_pu;
        do_reset();

        // vector table
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, r);
            chk({48'h0, r}, {48'h0, VECS[i].ex}, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R1 reset image
        do_reset();
        #1;
        chk(pin_oe, '0, "R1 pin_oe");
        chk(pin_pu, P3PU, "R1 pin_pu");
        chk(pin_out, '0, "R1 pin_out");
        rd(5'h07, r); chk({48'h0, r}, '0, "R1 gate reg");
        rd(5'h16, r); chk({48'h0, r}, '0, "R1 pull A");
        rd(5'h0A, r); chk({48'h0, r}, '0, "R1 dir port 2");

        // R7 pull A mapping
        for (int i = 0; i < 8; i++) begin
            wr(5'h16, 8'(1 << i));
            chk(pin_pu, grp(i) | P3PU, $sformatf("R7 pull A bit %0d", i));
        end
        wr(5'h16, 8'h00);
        // R8 pull B mapping
        for (int i = 0; i < 8; i++) begin
            wr(5'h17, 8'(1 << i));
            chk(pin_pu, ((i < 6) ? grp(8 + i) : 56'h0) | P3PU, $sformatf("R8 pull B bit %0d", i));
        end
        wr(5'h17, 8'hFF);
        chk(pin_pu[39:32], 8'hFE, "R8 port 4 pin 0 never pulled");
        wr(5'h17, 8'h00);

        // R9 output pins not pulled; R2 direction to enable
        wr(5'h16, 8'hFF);
        wr(5'h0A, 8'h0F);
        chk(pin_pu[23:16], 8'hF0, "R9 port 2 pulls");
        chk(pin_oe[23:16], 8'h0F, "R2 port 2 oe");
        wr(5'h08, 8'h01);
        chk(pin_pu[7:0], 8'h00, "R9 port 0 output no pull");
        chk(pin_oe[7:0], 8'hFF, "R5 port 0 whole port oe");

        // R10 segment override
        seg_assign = 24'hFF_FF_FF;
        wr(5'h17, 8'h01);
        chk(pin_pu[23:16], 8'h00, "R10 seg cancels pull A");
        chk(pin_pu[15:8], 8'h00, "R10 seg cancels pull A port 1");
        chk(pin_pu[39:32], 8'h0E, "R10 seg leaves pull B");
        seg_assign = '0;
        #1;
        chk(pin_pu[23:16], 8'hF0, "R10 seg released");

        // R6 port-3 gate, R11 timing
        wr(5'h0B, 8'hFF);
        chk(pin_oe[31:24], 8'h00, "R6 gate off no drive");
        chk(pin_pu[31:24], 8'hFF, "R6 gate off pulled");
        @(negedge clk);
        bus_addr = 5'h07; bus_wdata = 8'h01; bus_we = 1'b1;
        #1;
        chk(pin_oe[31:24], 8'h00, "R11 no effect before edge");
        @(negedge clk);
        bus_we = 1'b0;
        chk(pin_oe[31:24], 8'hFF, "R6 gate on drives");
        chk(pin_pu[31:24], 8'h00, "R6 gate on no pull");
        wr(5'h07, 8'h00);
        chk(pin_oe[31:24], 8'h00, "R6 gate back off");
        chk(pin_pu[31:24], 8'hFF, "R6 pulled again");

        // R4 write to input port
        wr(5'h05, 8'h3C);
        chk(pin_out[47:40], 8'h3C, "R4 latch updated");
        chk(pin_oe[47:40], 8'h00, "R4 input stays undriven");
        rd(5'h05, r); chk({48'h0, r}, 56'h81, "R3 input reads pin");

        // R11 unmapped writes change nothing
        #1;
        s_out = pin_out; s_oe = pin_oe; s_pu = pin_pu;
        wr(5'h0F, 8'hFF);
        wr(5'h15, 8'hFF);
        wr(5'h18, 8'hFF);
        wr(5'h1F, 8'hFF);
        chk(pin_out, s_out, "R11 unmapped pin_out");
        chk(pin_oe, s_oe, "R11 unmapped pin_oe");
        chk(pin_pu, s_pu, "R11 unmapped pin_pu");
        rd(5'h0F, r); chk({48'h0, r}, '0, "R11 unmapped read");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule